// File: doc/BRIEF.md
# Tagged Object Reference Access Checker

This block validates every memory access made through a tagged object reference before any address leaves it. A reference is 33 bits wide: one tag bit above a 32-bit word that packs a rights field and an object index. The block keeps a small bank of reference registers and a table of object descriptors. Each descriptor holds a base address, a size, a supported-operation mask and a valid flag. For each request it picks a reference register, looks up the descriptor that the reference's index names, and checks four things in a fixed order: the tag, the descriptor, the permission and the offset. It then returns either the physical address (base plus offset) or a fault code.

Only a privileged create request can set a reference's tag. An ordinary data write to a reference register always stores the word with the tag cleared, so software arithmetic can never forge a reference. Descriptors are loaded through a separate configuration port that is privileged by construction. Requests use a valid/ready handshake, and each accepted request produces exactly one result one cycle later.

Top module: `capAccessCheck`

## Requirements
- R1: An access (reqOp 0 read, 1 write, 2 delete) through a reference register whose tag bit (bit 32) is 0 returns fault code 1.
- R2: A data write (dataWrValid) stores dataWrData into the selected reference register with the tag at 0. When a create targets the same register in the same cycle, the data write wins and the tag ends at 0.
- R3: A create (reqOp 3) with reqPriv high stores reqData with the tag at 1 and returns fault 0 with address 0. Without reqPriv it returns fault 5 with address 0 and leaves the register unchanged.
- R4: Reference word layout: bits [27:0] are the object index, and bits [31:28] are rights (bit 28 read, bit 29 write, bit 30 delete, bit 31 type-specific). An index above 15, or one whose table entry is not valid, returns fault 4.
- R5: An access of operation k (0 read, 1 write, 2 delete) is permitted only when rights bit 28+k is set and bit k of the entry's type mask is set. Otherwise it returns fault 2.
- R6: An access whose offset is greater than or equal to the entry's size returns fault 3. An offset of size-1 is accepted.
- R7: A successful access returns fault 0 and rspAddr = (base + offset) mod 2^32. Every faulting response carries rspAddr = 0.
- R8: When several checks fail at once, the reported fault follows this priority: tag (1), then entry (4), then rights (2), then bounds (3).
- R9: reqReady is 0 during reset and 1 afterwards. A request accepted at one clock edge gives rspValid high for exactly the following cycle, with the result on rspFault/rspAddr.
- R10: A configuration write at a clock edge takes effect only for requests accepted at later edges. A request accepted at the same edge sees the old entry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgValid | input | 1 | Write one object table entry |
| cfgIdx | input | 4 | Table entry number |
| cfgEntryValid | input | 1 | Valid flag to store |
| cfgBase | input | 32 | Object base address |
| cfgSize | input | 32 | Object size |
| cfgType | input | 4 | Supported-operation mask (bit k = op k) |
| dataWrValid | input | 1 | Ordinary write into a reference register |
| dataWrSel | input | 3 | Reference register selected for the data write |
| dataWrData | input | 32 | Word to store (tag cleared) |
| reqValid | input | 1 | Request valid |
| reqReady | output | 1 | Request ready |
| reqOp | input | 2 | 0 read, 1 write, 2 delete, 3 create |
| reqSel | input | 3 | Reference register used by the request |
| reqOffset | input | 32 | Offset within the object |
| reqPriv | input | 1 | Privilege level of the request |
| reqData | input | 32 | Word to tag on create |
| rspValid | output | 1 | Result valid pulse |
| rspFault | output | 3 | Fault code (0 ok) |
| rspAddr | output | 32 | Physical address, 0 on fault |

## Verification
The hardest cases to reach are the collisions. One is a data write and a privileged create landing on the same reference register in the same cycle. The other is a configuration write and an access to the same entry at the same edge. Random stimulus almost never lines these up, so directed steps drive both inputs together and then read the outcome back through a later access. Multi-fault priority is reached with directed references that carry a cleared tag, an invalid index and no rights at once. Random traffic uses small sizes and offsets so that bounds hits and near misses are frequent.

// File: rtl/capPkg.sv
package capPkg;
  localparam int OP_KINDS = 4;

  typedef enum logic [2:0] {
    FLT_OK     = 3'd0,
    FLT_TAG    = 3'd1,
    FLT_RIGHTS = 3'd2,
    FLT_BOUNDS = 3'd3,
    FLT_ENTRY  = 3'd4,
    FLT_UNPRIV = 3'd5
  } faultT;

  typedef enum logic [1:0] {
    OP_READ   = 2'd0,
    OP_WRITE  = 2'd1,
    OP_DELETE = 2'd2,
    OP_CREATE = 2'd3
  } opT;

  typedef struct packed {
    logic  load;
    logic  create;
    logic  passAddr;
    faultT fault;
  } strobeT;

  typedef struct packed {
    logic                tag;
    logic                entryOk;
    logic                inBounds;
    logic [OP_KINDS-1:0] rights;
    logic [OP_KINDS-1:0] typeMask;
  } statusT;
endpackage

// File: rtl/capDatapath.sv
module capDatapath
  import capPkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int IDX_W       = 28,
  parameter int NUM_ENTRIES = 16,
  parameter int NUM_REFS    = 8
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          cfgValid,
  input  logic [$clog2(NUM_ENTRIES)-1:0] cfgIdx,
  input  logic                          cfgEntryValid,
  input  logic [ADDR_W-1:0]             cfgBase,
  input  logic [ADDR_W-1:0]             cfgSize,
  input  logic [OP_KINDS-1:0]           cfgType,
  input  logic                          dataWrValid,
  input  logic [$clog2(NUM_REFS)-1:0]   dataWrSel,
  input  logic [IDX_W+OP_KINDS-1:0]     dataWrData,
  input  logic [$clog2(NUM_REFS)-1:0]   reqSel,
  input  logic [ADDR_W-1:0]             reqOffset,
  input  logic [IDX_W+OP_KINDS-1:0]     reqData,
  input  strobeT                        ctlStb,
  output statusT                        sts,
  output logic [2:0]                    rspFault,
  output logic [ADDR_W-1:0]             rspAddr
);
  localparam int ENT_SEL_W = $clog2(NUM_ENTRIES);
  localparam int REF_SEL_W = $clog2(NUM_REFS);
  localparam int WORD_W    = IDX_W + OP_KINDS;

  logic [NUM_ENTRIES-1:0] entValid;
  logic [ADDR_W-1:0]      entBase [NUM_ENTRIES];
  logic [ADDR_W-1:0]      entSize [NUM_ENTRIES];
  logic [OP_KINDS-1:0]    entType [NUM_ENTRIES];

  logic [NUM_REFS-1:0]    refTag;
  logic [WORD_W-1:0]      refWord [NUM_REFS];

  logic [WORD_W-1:0]      selWord;
  logic [IDX_W-1:0]       selIdx;
  logic [ENT_SEL_W-1:0]   tblIdx;
  logic                   idxHigh;
  logic [ADDR_W-1:0]      addrSum;
  logic [2:0]             faultQ;
  logic [ADDR_W-1:0]      addrQ;

  // object table: one register slice per entry
  for (genvar e = 0; e < NUM_ENTRIES; e++) begin : gEnt
    always_ff @(posedge clk) begin
      if (!rstN) begin
        entValid[e] <= 1'b0;
        entBase[e]  <= '0;
        entSize[e]  <= '0;
        entType[e]  <= '0;
      end else if (cfgValid && cfgIdx == ENT_SEL_W'(e)) begin
        entValid[e] <= cfgEntryValid;
        entBase[e]  <= cfgBase;
        entSize[e]  <= cfgSize;
        entType[e]  <= cfgType;
      end
    end
  end

  // reference registers: a data write always wins and clears the tag
  for (genvar r = 0; r < NUM_REFS; r++) begin : gRef
    always_ff @(posedge clk) begin
      if (!rstN) begin
        refTag[r]  <= 1'b0;
        refWord[r] <= '0;
      end else if (dataWrValid && dataWrSel == REF_SEL_W'(r)) begin
        refTag[r]  <= 1'b0;
        refWord[r] <= dataWrData;
      end else if (ctlStb.create && reqSel == REF_SEL_W'(r)) begin
        refTag[r]  <= 1'b1;
        refWord[r] <= reqData;
      end
    end
  end

  always_comb begin
    selWord = refWord[reqSel];
    selIdx  = selWord[IDX_W-1:0];
    idxHigh = |selIdx[IDX_W-1:ENT_SEL_W];
    tblIdx  = selIdx[ENT_SEL_W-1:0];
    addrSum = entBase[tblIdx] + reqOffset;

    sts.tag      = refTag[reqSel];
    sts.rights   = selWord[WORD_W-1:IDX_W];
    sts.entryOk  = !idxHigh && entValid[tblIdx];
    sts.typeMask = entType[tblIdx];
    sts.inBounds = reqOffset < entSize[tblIdx];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      faultQ <= '0;
      addrQ  <= '0;
    end else if (ctlStb.load) begin
      faultQ <= ctlStb.fault;
      addrQ  <= ctlStb.passAddr ? addrSum : '0;
    end
  end

  assign rspFault = faultQ;
  assign rspAddr  = addrQ;

  // R2
  dataWrClears_chk: assert property (@(posedge clk) disable iff (!rstN)
    dataWrValid |=> !refTag[$past(dataWrSel)]);

  // R3
  unprivCreateKeeps_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctlStb.load && ctlStb.fault == FLT_UNPRIV &&
     !(dataWrValid && dataWrSel == reqSel))
    |=> refTag[$past(reqSel)] == $past(refTag[reqSel]));

  // R6
  passInBounds_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctlStb.passAddr |-> sts.inBounds && sts.entryOk);
endmodule

// File: rtl/capCtrl.sv
module capCtrl
  import capPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic [1:0] reqOp,
  input  logic       reqPriv,
  input  statusT     sts,
  output logic       reqReady,
  output logic       rspValid,
  output strobeT     ctlStb
);
  logic  readyQ;
  logic  rspValidQ;
  logic  accept;
  logic  isCreate;
  logic  permitted;
  faultT fault;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      readyQ    <= 1'b0;
      rspValidQ <= 1'b0;
    end else begin
      readyQ    <= 1'b1;
      rspValidQ <= accept;
    end
  end

  always_comb begin
    accept    = reqValid && readyQ;
    isCreate  = opT'(reqOp) == OP_CREATE;
    permitted = sts.rights[reqOp] && sts.typeMask[reqOp];
    if (isCreate)          fault = reqPriv ? FLT_OK : FLT_UNPRIV;
    else if (!sts.tag)     fault = FLT_TAG;
    else if (!sts.entryOk) fault = FLT_ENTRY;
    else if (!permitted)   fault = FLT_RIGHTS;
    else if (!sts.inBounds) fault = FLT_BOUNDS;
    else                   fault = FLT_OK;

    ctlStb.load     = accept;
    ctlStb.create   = accept && isCreate && reqPriv;
    ctlStb.passAddr = accept && !isCreate && fault == FLT_OK;
    ctlStb.fault    = fault;
  end

  assign reqReady = readyQ;
  assign rspValid = rspValidQ;

  // R3
  createNeedsPriv_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctlStb.create |-> reqPriv);

  // R8
  rightsAfterTagEntry_chk: assert property (@(posedge clk) disable iff (!rstN)
    (accept && fault == FLT_RIGHTS) |-> (sts.tag && sts.entryOk));

  // R9
  readyHolds_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |=> reqReady);

  // R9
  singlePulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !$past(reqValid)) |=> !rspValid || $past(reqValid));
endmodule

// File: rtl/capAccessCheck.sv
module capAccessCheck
  import capPkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int IDX_W       = 28,
  parameter int NUM_ENTRIES = 16,
  parameter int NUM_REFS    = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cfgValid,
  input  logic [3:0]  cfgIdx,
  input  logic        cfgEntryValid,
  input  logic [31:0] cfgBase,
  input  logic [31:0] cfgSize,
  input  logic [3:0]  cfgType,
  input  logic        dataWrValid,
  input  logic [2:0]  dataWrSel,
  input  logic [31:0] dataWrData,
  input  logic        reqValid,
  output logic        reqReady,
  input  logic [1:0]  reqOp,
  input  logic [2:0]  reqSel,
  input  logic [31:0] reqOffset,
  input  logic        reqPriv,
  input  logic [31:0] reqData,
  output logic        rspValid,
  output logic [2:0]  rspFault,
  output logic [31:0] rspAddr
);
  strobeT ctlStb;
  statusT sts;

  capCtrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqOp    (reqOp),
    .reqPriv  (reqPriv),
    .sts      (sts),
    .reqReady (reqReady),
    .rspValid (rspValid),
    .ctlStb   (ctlStb)
  );

  capDatapath #(
    .ADDR_W      (ADDR_W),
    .IDX_W       (IDX_W),
    .NUM_ENTRIES (NUM_ENTRIES),
    .NUM_REFS    (NUM_REFS)
  ) uDp (
    .clk           (clk),
    .rstN          (rstN),
    .cfgValid      (cfgValid),
    .cfgIdx        (cfgIdx),
    .cfgEntryValid (cfgEntryValid),
    .cfgBase       (cfgBase),
    .cfgSize       (cfgSize),
    .cfgType       (cfgType),
    .dataWrValid   (dataWrValid),
    .dataWrSel     (dataWrSel),
    .dataWrData    (dataWrData),
    .reqSel        (reqSel),
    .reqOffset     (reqOffset),
    .reqData       (reqData),
    .ctlStb        (ctlStb),
    .sts           (sts),
    .rspFault      (rspFault),
    .rspAddr       (rspAddr)
  );

  // R7
  faultNoAddr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspFault != 3'd0) |-> rspAddr == '0);
endmodule

// File: tb/tb_capAccessCheck.sv
module tb_capAccessCheck;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgValid = 0, cfgEntryValid = 0;
  logic [3:0]  cfgIdx = 0, cfgType = 0;
  logic [31:0] cfgBase = 0, cfgSize = 0;
  logic        dataWrValid = 0;
  logic [2:0]  dataWrSel = 0;
  logic [31:0] dataWrData = 0;
  logic        reqValid = 0, reqPriv = 0;
  logic [1:0]  reqOp = 0;
  logic [2:0]  reqSel = 0;
  logic [31:0] reqOffset = 0, reqData = 0;
  logic        reqReady, rspValid;
  logic [2:0]  rspFault;
  logic [31:0] rspAddr;

  int nTests = 0, nFail = 0;
  bit done = 0;

  // model state
  logic        mTag   [8];
  logic [31:0] mWord  [8];
  logic        mValid [16];
  logic [31:0] mBase  [16];
  logic [31:0] mSize  [16];
  logic [3:0]  mType  [16];

  always #10 clk = ~clk;   // 50 MHz

  capAccessCheck dut (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [34:0] expResult(input logic [1:0] op, input logic [2:0] sel,
                                           input logic [31:0] off, input logic priv);
    logic [31:0] w;
    logic [3:0] e;
    w = mWord[sel];
    e = w[3:0];
    if (op == 2'd3) return {priv ? 3'd0 : 3'd5, 32'd0};
    if (!mTag[sel]) return {3'd1, 32'd0};
    if (w[27:4] != 0 || !mValid[e]) return {3'd4, 32'd0};
    if (!(w[28 + op] && mType[e][op])) return {3'd2, 32'd0};
    if (off >= mSize[e]) return {3'd3, 32'd0};
    return {3'd0, mBase[e] + off};
  endfunction

  // one cycle: inputs already driven at negedge; check the result at the next negedge
  task automatic cycle(input string req);
    logic [34:0] ex;
    logic doReq;
    doReq = reqValid;
    ex = expResult(reqOp, reqSel, reqOffset, reqPriv);
    @(posedge clk);
    @(negedge clk);
    if (doReq) begin
      check(req, {31'd0, rspValid}, 32'd1);
      check(req, {29'd0, rspFault}, {29'd0, ex[34:32]});
      check(req, rspAddr, ex[31:0]);
      if (reqOp == 2'd3 && reqPriv) begin mTag[reqSel] = 1'b1; mWord[reqSel] = reqData; end
    end
    if (dataWrValid) begin mTag[dataWrSel] = 1'b0; mWord[dataWrSel] = dataWrData; end
    if (cfgValid) begin
      mValid[cfgIdx] = cfgEntryValid; mBase[cfgIdx] = cfgBase;
      mSize[cfgIdx] = cfgSize; mType[cfgIdx] = cfgType;
    end
    cfgValid = 0; dataWrValid = 0; reqValid = 0;
  endtask

  task automatic setCfg(input logic [3:0] i, input logic v, input logic [31:0] b,
                        input logic [31:0] s, input logic [3:0] t);
    cfgValid = 1; cfgIdx = i; cfgEntryValid = v; cfgBase = b; cfgSize = s; cfgType = t;
  endtask

  task automatic setReq(input logic [1:0] op, input logic [2:0] sel, input logic [31:0] off,
                        input logic priv, input logic [31:0] d);
    reqValid = 1; reqOp = op; reqSel = sel; reqOffset = off; reqPriv = priv; reqData = d;
  endtask

  task automatic setDw(input logic [2:0] sel, input logic [31:0] d);
    dataWrValid = 1; dataWrSel = sel; dataWrData = d;
  endtask

  initial begin
    for (int i = 0; i < 8; i++) begin mTag[i] = 0; mWord[i] = 0; end
    for (int i = 0; i < 16; i++) begin mValid[i] = 0; mBase[i] = 0; mSize[i] = 0; mType[i] = 0; end
    void'($urandom(32'h5EED_0960));
    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9 ready in reset", {31'd0, reqReady}, 32'd0);
    check("R9 rspValid in reset", {31'd0, rspValid}, 32'd0);
    rstN = 1;
    @(negedge clk);
    check("R9 ready after reset", {31'd0, reqReady}, 32'd1);

    // table entry 2: base 1000, size 16, read+write
    setCfg(4'd2, 1, 32'h1000, 32'd16, 4'b0011); cycle("cfg");
    // R1 untagged register
    setDw(3'd0, 32'h3000_0002); cycle("dw");
    setReq(2'd0, 3'd0, 32'd4, 0, 0); cycle("R1 untagged access");
    // R3 unprivileged create, then register still untagged
    setReq(2'd3, 3'd0, 0, 0, 32'h3000_0002); cycle("R3 unpriv create");
    setReq(2'd0, 3'd0, 32'd4, 0, 0); cycle("R3 tag unchanged");
    // R3 privileged create then R7 success
    setReq(2'd3, 3'd0, 0, 1, 32'h3000_0002); cycle("R3 priv create");
    setReq(2'd0, 3'd0, 32'd4, 0, 0); cycle("R7 read ok");
    // R6 bounds edge
    setReq(2'd1, 3'd0, 32'd15, 0, 0); cycle("R6 size-1 ok");
    setReq(2'd1, 3'd0, 32'd16, 0, 0); cycle("R6 offset==size");
    // R5 delete right absent
    setReq(2'd2, 3'd0, 32'd0, 0, 0); cycle("R5 delete denied");
    // R5 rights present, type lacks write
    setCfg(4'd3, 1, 32'h2000, 32'd8, 4'b0001); cycle("cfg");
    setReq(2'd3, 3'd1, 0, 1, 32'h3000_0003); cycle("R3 create");
    setReq(2'd1, 3'd1, 32'd0, 0, 0); cycle("R5 type lacks write");
    // R4 index above 15 and invalid entry
    setReq(2'd3, 3'd2, 0, 1, 32'h3000_0010); cycle("R3 create");
    setReq(2'd0, 3'd2, 32'd0, 0, 0); cycle("R4 index>15");
    setReq(2'd3, 3'd3, 0, 1, 32'h0000_0007); cycle("R3 create");
    // R8 entry beats rights and bounds
    setReq(2'd0, 3'd3, 32'd99, 0, 0); cycle("R8 entry first");
    // R8 tag beats all
    setDw(3'd3, 32'h0000_0017); cycle("dw");
    setReq(2'd0, 3'd3, 32'd99, 0, 0); cycle("R8 tag first");
    // R8 rights before bounds
    setReq(2'd1, 3'd1, 32'd50, 0, 0); cycle("R8 rights before bounds");
    // R2 data write and create same register same cycle
    setDw(3'd4, 32'h1000_0002); setReq(2'd3, 3'd4, 0, 1, 32'h1000_0002); cycle("R2 collide create");
    setReq(2'd0, 3'd4, 32'd1, 0, 0); cycle("R2 tag cleared");
    // R10 config at same edge as access sees old entry
    setCfg(4'd2, 1, 32'h5000, 32'd4, 4'b0011); setReq(2'd0, 3'd0, 32'd8, 0, 0);
    cycle("R10 same edge old entry");
    setReq(2'd0, 3'd0, 32'd8, 0, 0); cycle("R10 next edge new entry");
    // R7 address wrap
    setCfg(4'd5, 1, 32'hFFFF_FFF0, 32'h100, 4'b0111); cycle("cfg");
    setReq(2'd3, 3'd5, 0, 1, 32'h7000_0005); cycle("R3 create");
    setReq(2'd2, 3'd5, 32'h20, 0, 0); cycle("R7 wrap");
    // R9 no response without a request
    @(negedge clk);
    check("R9 single pulse", {31'd0, rspValid}, 32'd0);

    // random traffic
    for (int n = 0; n < 4000; n++) begin
      int k;
      k = int'($urandom_range(0, 9));
      if (k == 0) setCfg(4'($urandom), 1'($urandom_range(0, 5) != 0), $urandom,
                         32'($urandom_range(1, 48)), 4'($urandom));
      if (k == 1) setDw(3'($urandom), {4'($urandom), 24'($urandom_range(0, 1) * $urandom_range(0, 3)),
                                       4'($urandom)});
      if (k >= 2) begin
        if ($urandom_range(0, 5) == 0)
          setReq(2'd3, 3'($urandom), 0, 1'($urandom_range(0, 3) != 0),
                 {4'($urandom), 24'($urandom_range(0, 7) == 0), 4'($urandom)});
        else
          setReq(2'($urandom_range(0, 2)), 3'($urandom), 32'($urandom_range(0, 60)), 0, 0);
      end
      cycle("R7 random");
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nTests++; nFail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end
endmodule